// File: doc/BRIEF.md
# Tree-Based Expression Annotation Unit

This unit labels every cell of a fixed-width row of symbol cells. Together the cells hold a bracketed expression, one symbol per cell, and cell 0 is the leftmost. Each symbol arrives as a 3-bit class code. A one-cycle start pulse captures the class codes and an occupancy mask. The unit then returns four results for every cell: a position number, a nesting level, and a short vector of path selectors that locate the cell in the expression tree. It also returns the deepest level it found.

Two identical balanced binary combining trees produce the running sums. Each tree first sweeps upward, one tree level per clock. Every node adds its two children and keeps the left-hand partial sum. The tree then sweeps downward, one level per clock. Every node hands its own value to the left child and that value plus the kept left sum to the right child. Each leaf ends with the exclusive prefix sum of everything to its left. One tree sums occupancy and the other sums the nesting deltas. A final stage derives the levels and selectors from these sums and registers every result, then raises a one-cycle done pulse.

Top module: `annot_unit`

## Requirements
- R1: After reset, every per-cell output and the depth output are zero, and done_o is low.
- R2: A start_i sampled high while the unit is idle captures cls_i and valid_i. done_o is high for exactly one cycle, 2*log2(N_CELLS)+1 rising edges after the capturing edge (9 edges for 16 cells), and the results are on the outputs from that cycle onward.
- R3: A start_i that arrives while a computation is in flight is ignored: no extra done pulse follows, and the results belong to the first capture.
- R4: Cells with their valid_i bit set are numbered 1, 2, 3, … from left to right, counting occupied cells only. A masked cell reports index 0.
- R5: Class codes are 1 = open paren, 2 = open bracket, 3 = close paren, 4 = close bracket, 0 = plain symbol. The level of a cell is the inclusive running sum of +1 for each opener and −1 for each closer, minus one when the cell itself is an opener. The level is a two's-complement value.
- R6: max_depth_o is the largest level over all cells, and never less than zero.
- R7: Selector 1 of a cell counts the cells up to and including this one whose adjusted level is 1. The adjusted level is 0 for closers and equals the level otherwise. Selector 1 never restarts.
- R8: Selector k, for k > 1, counts the cells with adjusted level k since the most recent cell with adjusted level k−1, and restarts from zero at such a cell.
- R9: A selector k is forced to zero for any cell whose level is below k.
- R10: Between done pulses the outputs hold their values, whatever cls_i and valid_i do.
- R11: Class codes 5, 6 and 7 behave exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture request, honoured when idle |
| cls_i | input | N_CELLS*3 | Class code of cell c at bits [3c +: 3] |
| valid_i | input | N_CELLS | Occupancy mask, bit c for cell c |
| index_o | output | N_CELLS*IDX_W | Position number of cell c at [c*IDX_W +: IDX_W] |
| level_o | output | N_CELLS*LVL_W | Signed nesting level of cell c at [c*LVL_W +: LVL_W] |
| sel_o | output | N_CELLS*N_SEL*SEL_W | Selector k of cell c at [(c*N_SEL+k-1)*SEL_W +: SEL_W] |
| max_depth_o | output | LVL_W | Deepest level found |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The properties assume that start_i is a clean synchronous level and that the capture of valid_i bit 0 at an idle start is the one that the done pulse reports. They also assume that selector counts stay within SEL_W bits, which 16 cells guarantee for 4-bit selectors. The stimulus drives start_i for one cycle away from the clock edge, re-asserts it only mid-flight to probe the ignore rule, and uses expressions of at most 16 symbols. As a result, no counter wraps and only well-defined class codes or the reserved codes 5 to 7 reach the unit.

// File: rtl/annot_pkg.sv
package annot_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_PLAIN   = 3'd0,
    CLS_OPEN_P  = 3'd1,
    CLS_OPEN_B  = 3'd2,
    CLS_CLOSE_P = 3'd3,
    CLS_CLOSE_B = 3'd4
  } sym_cls_e;

  function automatic logic is_opener(input logic [CLS_W-1:0] c);
    return (c == CLS_OPEN_P) || (c == CLS_OPEN_B);
  endfunction

  function automatic logic is_closer(input logic [CLS_W-1:0] c);
    return (c == CLS_CLOSE_P) || (c == CLS_CLOSE_B);
  endfunction
endpackage

// File: rtl/annot_ctrl.sv
module annot_ctrl #(
  parameter int LOG_N = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic [LOG_N-1:0] up_en_o,
  output logic [LOG_N-1:0] dn_en_o,
  output logic             fin_o,
  output logic             done_o
);
  localparam int LAST  = 2 * LOG_N;
  localparam int CNT_W = $clog2(LAST + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign load_o = start_i && !busy_q;
  assign fin_o  = busy_q && (cnt_q == CNT_W'(LAST));
  assign done_o = done_q;

  // up_en[l]: write nodes of height l+1; dn_en[l]: height l+1 feeds its children
  for (genvar l = 0; l < LOG_N; l++) begin : g_en
    assign up_en_o[l] = busy_q && (cnt_q == CNT_W'(l));
    assign dn_en_o[l] = busy_q && (cnt_q == CNT_W'(2 * LOG_N - 1 - l));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (fin_o) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/annot_scan_tree.sv
module annot_scan_tree #(
  parameter int N = 16,
  parameter int W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [$clog2(N)-1:0] up_en_i,
  input  logic [$clog2(N)-1:0] dn_en_i,
  input  logic [N-1:0][W-1:0] leaf_i,
  output logic [N-1:0][W-1:0] excl_o
);
  localparam int LOG_N = $clog2(N);

  // heap numbering: node n has children 2n, 2n+1; leaf c sits at N+c
  logic [W-1:0] lf_q   [N];
  logic [W-1:0] sum_q  [2:N-1];
  logic [W-1:0] left_q [1:N-1];
  logic [W-1:0] dn_q   [2:2*N-1];
  logic [W-1:0] up_w   [2:2*N-1];

  always_comb begin
    for (int x = 2; x < N; x++) up_w[x] = sum_q[x];
    for (int c = 0; c < N; c++) up_w[N+c] = lf_q[c];
  end

  always_comb begin
    for (int c = 0; c < N; c++) excl_o[c] = dn_q[N+c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < N; c++) lf_q[c] <= '0;
      for (int x = 2; x < N; x++) sum_q[x] <= '0;
      for (int x = 1; x < N; x++) left_q[x] <= '0;
      for (int x = 2; x < 2 * N; x++) dn_q[x] <= '0;
    end else begin
      if (load_i) begin
        for (int c = 0; c < N; c++) lf_q[c] <= leaf_i[c];
      end
      // upsweep: keep left child, pass sum upward (root needs no sum)
      for (int lv = 1; lv <= LOG_N; lv++) begin
        if (up_en_i[lv-1]) begin
          for (int j = 0; j < (N >> lv); j++)
            left_q[(N>>lv)+j] <= up_w[2*((N>>lv)+j)];
        end
      end
      for (int lv = 1; lv < LOG_N; lv++) begin
        if (up_en_i[lv-1]) begin
          for (int j = 0; j < (N >> lv); j++)
            sum_q[(N>>lv)+j] <= up_w[2*((N>>lv)+j)] + up_w[2*((N>>lv)+j)+1];
        end
      end
      // downsweep: root starts from zero
      if (dn_en_i[LOG_N-1]) begin
        dn_q[2] <= '0;
        dn_q[3] <= left_q[1];
      end
      for (int lv = 1; lv < LOG_N; lv++) begin
        if (dn_en_i[lv-1]) begin
          for (int j = 0; j < (N >> lv); j++) begin
            dn_q[2*((N>>lv)+j)]   <= dn_q[(N>>lv)+j];
            dn_q[2*((N>>lv)+j)+1] <= dn_q[(N>>lv)+j] + left_q[(N>>lv)+j];
          end
        end
      end
    end
  end
endmodule

// File: rtl/annot_select.sv
module annot_select #(
  parameter int N     = 16,
  parameter int LVL_W = 6,
  parameter int N_SEL = 3,
  parameter int SEL_W = 4
) (
  input  logic [N-1:0][LVL_W-1:0]             lvl_i,
  input  logic [N-1:0]                        close_i,
  output logic [N-1:0][N_SEL-1:0][SEL_W-1:0]  sel_o
);
  logic [LVL_W-1:0] adj [N];
  logic [SEL_W-1:0] run;

  always_comb begin
    for (int c = 0; c < N; c++) adj[c] = close_i[c] ? '0 : lvl_i[c];
  end

  always_comb begin
    run = '0;
    for (int k = 1; k <= N_SEL; k++) begin
      run = '0;
      for (int c = 0; c < N; c++) begin
        if (adj[c] == LVL_W'(k))
          run = run + 1'b1;
        else if ((k > 1) && (adj[c] == LVL_W'(k - 1)))
          run = '0;
        sel_o[c][k-1] = ($signed(lvl_i[c]) >= $signed(LVL_W'(k))) ? run : '0;
      end
    end
  end
endmodule

// File: rtl/annot_unit.sv
module annot_unit
  import annot_pkg::*;
#(
  parameter int N_CELLS = 16,
  parameter int N_SEL   = 3,
  parameter int SEL_W   = 4,
  parameter int IDX_W   = $clog2(N_CELLS) + 1,
  parameter int LVL_W   = $clog2(N_CELLS) + 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             start_i,
  input  logic [N_CELLS*CLS_W-1:0]         cls_i,
  input  logic [N_CELLS-1:0]               valid_i,
  output logic [N_CELLS*IDX_W-1:0]         index_o,
  output logic [N_CELLS*LVL_W-1:0]         level_o,
  output logic [N_CELLS*N_SEL*SEL_W-1:0]   sel_o,
  output logic [LVL_W-1:0]                 max_depth_o,
  output logic                             done_o
);
  localparam int LOG_N = $clog2(N_CELLS);

  logic             load;
  logic [LOG_N-1:0] up_en, dn_en;
  logic             fin;

  logic [N_CELLS-1:0][IDX_W-1:0] idx_leaf, idx_excl, idx_w, idx_q;
  logic [N_CELLS-1:0][LVL_W-1:0] lvl_leaf, lvl_excl, lvl_w, lvl_q;
  logic [N_CELLS-1:0][N_SEL-1:0][SEL_W-1:0] sel_w, sel_q;
  logic [N_CELLS-1:0] close_q, val_q;
  logic [LVL_W-1:0]   max_w, max_q;

  annot_ctrl #(.LOG_N(LOG_N)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .up_en_o (up_en),
    .dn_en_o (dn_en),
    .fin_o   (fin),
    .done_o  (done_o)
  );

  always_comb begin
    for (int c = 0; c < N_CELLS; c++) begin
      idx_leaf[c] = {{(IDX_W-1){1'b0}}, valid_i[c]};
      if (is_opener(cls_i[c*CLS_W +: CLS_W]))      lvl_leaf[c] = LVL_W'(1);
      else if (is_closer(cls_i[c*CLS_W +: CLS_W])) lvl_leaf[c] = {LVL_W{1'b1}};
      else                                         lvl_leaf[c] = '0;
    end
  end

  annot_scan_tree #(.N(N_CELLS), .W(IDX_W)) u_idx_tree (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .up_en_i (up_en),
    .dn_en_i (dn_en),
    .leaf_i  (idx_leaf),
    .excl_o  (idx_excl)
  );

  annot_scan_tree #(.N(N_CELLS), .W(LVL_W)) u_lvl_tree (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .up_en_i (up_en),
    .dn_en_i (dn_en),
    .leaf_i  (lvl_leaf),
    .excl_o  (lvl_excl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      close_q <= '0;
      val_q   <= '0;
    end else if (load) begin
      val_q <= valid_i;
      for (int c = 0; c < N_CELLS; c++)
        close_q[c] <= is_closer(cls_i[c*CLS_W +: CLS_W]);
    end
  end

  // exclusive sum already drops the opener's own +1; closers take their -1
  always_comb begin
    for (int c = 0; c < N_CELLS; c++) begin
      lvl_w[c] = lvl_excl[c] - (close_q[c] ? LVL_W'(1) : LVL_W'(0));
      idx_w[c] = val_q[c] ? idx_excl[c] + IDX_W'(1) : '0;
    end
  end

  always_comb begin
    max_w = '0;
    for (int c = 0; c < N_CELLS; c++)
      if ($signed(lvl_w[c]) > $signed(max_w)) max_w = lvl_w[c];
  end

  annot_select #(
    .N(N_CELLS), .LVL_W(LVL_W), .N_SEL(N_SEL), .SEL_W(SEL_W)
  ) u_select (
    .lvl_i   (lvl_w),
    .close_i (close_q),
    .sel_o   (sel_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      lvl_q <= '0;
      sel_q <= '0;
      max_q <= '0;
    end else if (fin) begin
      idx_q <= idx_w;
      lvl_q <= lvl_w;
      sel_q <= sel_w;
      max_q <= max_w;
    end
  end

  assign index_o     = idx_q;
  assign level_o     = lvl_q;
  assign sel_o       = sel_q;
  assign max_depth_o = max_q;
endmodule

// File: rtl/annot_unit_chk.sv
module annot_unit_chk #(
  parameter int N_CELLS = 16,
  parameter int N_SEL   = 3,
  parameter int SEL_W   = 4,
  parameter int IDX_W   = 5,
  parameter int LVL_W   = 6
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           start_i,
  input logic [N_CELLS-1:0]             valid_i,
  input logic [N_CELLS*IDX_W-1:0]       index_o,
  input logic [N_CELLS*LVL_W-1:0]       level_o,
  input logic [N_CELLS*N_SEL*SEL_W-1:0] sel_o,
  input logic [LVL_W-1:0]               max_depth_o,
  input logic                           done_o
);
  localparam int LAST  = 2 * $clog2(N_CELLS);
  localparam int CNT_W = $clog2(LAST + 1);

  logic             c_busy, c_v0;
  logic [CNT_W-1:0] c_cnt;
  logic             c_hit;

  assign c_hit = c_busy && (c_cnt == CNT_W'(LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_busy <= 1'b0;
      c_cnt  <= '0;
      c_v0   <= 1'b0;
    end else if (!c_busy && start_i) begin
      c_busy <= 1'b1;
      c_cnt  <= '0;
      c_v0   <= valid_i[0];
    end else if (c_hit) begin
      c_busy <= 1'b0;
    end else if (c_busy) begin
      c_cnt <= c_cnt + 1'b1;
    end
  end

  function automatic logic gated_ok(input logic [N_CELLS*LVL_W-1:0] l,
                                    input logic [N_CELLS*N_SEL*SEL_W-1:0] s);
    for (int c = 0; c < N_CELLS; c++)
      for (int k = 1; k <= N_SEL; k++)
        if ($signed(l[c*LVL_W +: LVL_W]) < $signed(LVL_W'(k)) &&
            s[(c*N_SEL+k-1)*SEL_W +: SEL_W] != '0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic under_max(input logic [N_CELLS*LVL_W-1:0] l,
                                     input logic [LVL_W-1:0] m);
    if ($signed(m) < 0) return 1'b0;
    for (int c = 0; c < N_CELLS; c++)
      if ($signed(l[c*LVL_W +: LVL_W]) > $signed(m)) return 1'b0;
    return 1'b1;
  endfunction

  AST_DONE_ON_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_hit |=> done_o); // R2
  AST_DONE_ONLY_ON_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(c_hit)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_FIRST_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (index_o[IDX_W-1:0] == (c_v0 ? IDX_W'(1) : IDX_W'(0)))); // R4
  AST_SEL_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> gated_ok(level_o, sel_o)); // R9
  AST_MAX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> under_max(level_o, max_depth_o)); // R6
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(index_o) && $stable(level_o) &&
                 $stable(sel_o) && $stable(max_depth_o))); // R10
endmodule

bind annot_unit annot_unit_chk #(
  .N_CELLS(N_CELLS), .N_SEL(N_SEL), .SEL_W(SEL_W), .IDX_W(IDX_W), .LVL_W(LVL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .valid_i     (valid_i),
  .index_o     (index_o),
  .level_o     (level_o),
  .sel_o       (sel_o),
  .max_depth_o (max_depth_o),
  .done_o      (done_o)
);

// File: tb/annot_unit_tb.sv
`timescale 1ns/1ps
module annot_unit_tb;
  localparam int N = 16, NS = 3, SW = 4, IW = 5, LW = 6, LAT = 9;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N*3-1:0]     cls = '0;
  logic [N-1:0]       valid = '0;
  logic [N*IW-1:0]    index_o;
  logic [N*LW-1:0]    level_o;
  logic [N*NS*SW-1:0] sel_o;
  logic [LW-1:0]      maxd_o;
  logic               done;

  int n_chk = 0, n_fail = 0;
  int e_idx [N];
  int e_lvl [N];
  int e_sel [N][NS];
  int e_max;

  always #2 clk = ~clk;

  annot_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cls_i(cls), .valid_i(valid),
    .index_o(index_o), .level_o(level_o), .sel_o(sel_o),
    .max_depth_o(maxd_o), .done_o(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int code_of(input byte ch);
    case (ch)
      "(": return 1;
      "<": return 2;
      ")": return 3;
      ">": return 4;
      "5": return 5;
      "6": return 6;
      "7": return 7;
      default: return 0;
    endcase
  endfunction

  task automatic drive(input string s);
    for (int c = 0; c < N; c++) begin
      cls[c*3 +: 3] = 3'(code_of(s[c]));
      valid[c]      = (s[c] != ".");
    end
  endtask

  // reference built straight from the requirement text
  task automatic model(input string s);
    int run = 0, num = 0, cnt[NS+1];
    e_max = 0;
    for (int k = 0; k <= NS; k++) cnt[k] = 0;
    for (int c = 0; c < N; c++) begin
      int cd = code_of(s[c]);
      bit op = (cd == 1 || cd == 2), cl = (cd == 3 || cd == 4);
      int adj;
      if (s[c] != ".") num++;
      e_idx[c] = (s[c] != ".") ? num : 0;
      run += op ? 1 : (cl ? -1 : 0);
      e_lvl[c] = run - (op ? 1 : 0);
      if (e_lvl[c] > e_max) e_max = e_lvl[c];
      adj = cl ? 0 : e_lvl[c];
      for (int k = 1; k <= NS; k++) begin
        if (adj == k) cnt[k]++;
        else if (k > 1 && adj == k - 1) cnt[k] = 0;
        e_sel[c][k-1] = (e_lvl[c] >= k) ? (cnt[k] % 16) : 0;
      end
    end
  endtask

  task automatic compare_all();
    for (int c = 0; c < N; c++) begin
      chk("R4 index", int'(index_o[c*IW +: IW]), e_idx[c]);
      chk("R5 level", int'($signed(level_o[c*LW +: LW])), e_lvl[c]);
      for (int k = 1; k <= NS; k++) begin
        int act = int'(sel_o[(c*NS+k-1)*SW +: SW]);
        if (e_lvl[c] < k)  chk("R9 gated selector", act, e_sel[c][k-1]);
        else if (k == 1)   chk("R7 selector 1", act, e_sel[c][k-1]);
        else               chk("R8 selector k", act, e_sel[c][k-1]);
      end
    end
    chk("R6 max depth", int'($signed(maxd_o)), e_max);
  endtask

  // start, optional mid-flight restart with another pattern, timing and results
  task automatic run_case(input string s, input bit poke, input string s2);
    @(negedge clk);
    drive(s);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= LAT; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && i == 3) begin
        drive(s2);
        start = 1'b1;
      end
      if (i < LAT) chk("R2 done early", int'(done), 0);
      else         chk("R2 done on time", int'(done), 1);
    end
    model(s);
    compare_all();
    @(negedge clk);
    chk("R2 done single cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    chk("R1 done", int'(done), 0);
    chk("R1 index", int'(index_o != '0), 0);
    chk("R1 level", int'(level_o != '0), 0);
    chk("R1 sel", int'(sel_o != '0), 0);
    chk("R1 max", int'(maxd_o), 0);
  endtask

  task automatic t_transpose();
    run_case("(x<<xxx><xxx>>).", 1'b0, "");
    // spot values for the worked example
    chk("R5 level cell6", int'($signed(level_o[6*LW +: LW])), 3);
    chk("R7 sel1 cell2", int'(sel_o[(2*NS)*SW +: SW]), 2);
    chk("R8 sel3 cell6", int'(sel_o[(6*NS+2)*SW +: SW]), 3);
  endtask

  task automatic t_masked();
    run_case("x.(.x<x.>.)x..xx", 1'b0, "");
  endtask

  task automatic t_deep();
    run_case("((((x))))<<>>x(x", 1'b0, "");
    chk("R6 deep max", int'($signed(maxd_o)), 4);
  endtask

  task automatic t_flat();
    run_case("<xxxxxxxxxxxxxx>", 1'b0, "");
  endtask

  task automatic t_reserved();
    // R11: codes 5..7 must match plain symbols
    run_case("(5<6x7>)xx567...", 1'b0, "");
    model("(x<xxx>)xxxxx...");
    compare_all();
  endtask

  task automatic t_busy();
    // R3: second start during the run is dropped
    run_case("<(x)<x>>xxxxxxxx", 1'b1, "((((((((((((((((");
    for (int i = 0; i < LAT + 2; i++) begin
      @(negedge clk);
      chk("R3 no extra done", int'(done), 0);
    end
    compare_all();
  endtask

  task automatic t_hold();
    run_case("(x(x(x)x)x)x....", 1'b0, "");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      drive((i % 2) ? "<<<<<<<<<<<<<<<<" : "))))))))........");
    end
    compare_all(); // R10
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_transpose();
    t_masked();
    t_deep();
    t_flat();
    t_reserved();
    t_busy();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule